// File: doc/BRIEF.md
# SD Card Clock Prescaler and Divisor Generator

This block derives the SD card clock from a base clock. The divide ratio is the product of a power-of-two prescaler and a linear divisor. When it gets a start strobe, the block captures the base frequency, the requested frequency and a vendor-version value. It then runs a two-stage sequential search. The first stage fixes the prescaler. The second stage fixes the divisor. The search picks the smallest settings whose output frequency does not exceed the request.

While the new settings are worked out, the internal, host and peripheral clock enables are held off and the divider fields are held at zero. The new fields, the three enables and the achieved frequency then appear together. A done pulse follows one cycle later.

The divided clock is a registered waveform. It switches to a new ratio only at the end of a full period, so changing the settings never produces a shortened pulse.

Top module: `sdclk_divgen`

## Requirements
- R1: When start is sampled with a requested frequency of zero, all three enables stay low and both fields read zero. The achieved frequency reads zero, and done is high in the cycle after the start edge.
- R2: The prescaler begins at 2 when the vendor version is below 0x13, and at 1 otherwise. It doubles while floor(base / prescaler / 16) exceeds the request and the prescaler is below 256.
- R3: With the prescaler fixed, the divisor begins at 1. It increments while floor(base / prescaler / divisor) exceeds the request and the divisor is below 16.
- R4: The 8-bit prescaler field carries the prescaler shifted right by one (0 for a prescaler of 1). The 4-bit divisor field carries the divisor minus one.
- R5: On the start edge the three enables and both fields are cleared, and they stay cleared for the whole search. All three enables then rise on the same edge that loads the new fields.
- R6: The achieved frequency is floor(floor(base / prescaler) / divisor). With a request of 1 and a large base, this gives the lowest reachable value, base / 256 / 16.
- R7: Each prescaler or divisor iteration takes one clock. Let S be the number of prescaler steps plus the number of divisor steps, counting each stage's final test. Let W be the frequency width (32). The enables rise after edge S+W+1, counted from the start edge as edge 0. Done is high for exactly one cycle, after edge S+W+2.
- R8: A start strobe that arrives while a search is running is ignored. The result is that of the first request.
- R9: While enabled, the divided clock has a period of max(2, prescaler × divisor) base cycles. It is high for floor(period / 2) of those cycles. Once stopped, it stays low.
- R10: A new divide ratio is adopted only at the end of a complete period of the divided clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a new search when the block is idle |
| base_freq_i | input | 32 | Base clock frequency |
| req_freq_i | input | 32 | Requested SD clock frequency |
| vendor_ver_i | input | 8 | Vendor version, selects the starting prescaler |
| pre_field_o | output | 8 | Encoded prescaler (prescaler / 2) |
| div_field_o | output | 4 | Encoded divisor (divisor - 1) |
| int_clk_en_o | output | 1 | Internal clock enable |
| host_clk_en_o | output | 1 | Host clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable, also runs the divided clock |
| sd_clk_o | output | 1 | Divided SD clock |
| done_o | output | 1 | One-cycle pulse when the new settings are in place |
| act_freq_o | output | 32 | Achieved SD clock frequency |

## Verification
For every case, the bench works out the prescaler, the divisor and the step count S by plain arithmetic. From these it predicts that done appears S+35 edges after the start edge, or on the first edge for a zero request. It counts edges while sampling at falling edges, and checks that done arrives on exactly that count. It also checks that the enables were low two samples before done and high one sample before.

The gating check is made on the first falling edge after the start edge. The one-cycle width of done is checked on the sample that follows it. The divided-clock period and high time are measured between two rising edges seen after done. Any period still in flight from the old ratio is thereby excluded.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PRE   = 3'd1,
        S_DIV   = 3'd2,
        S_QUOT  = 3'd3,
        S_APPLY = 3'd4
    } srch_state_e;

endpackage

// File: rtl/sdclk_quot.sv
module sdclk_quot #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dvd_i,
    input  logic [DVS_W-1:0] dvs_i,
    output logic             done_o,
    output logic [DVD_W-1:0] quo_o
);

    localparam int CNT_W = $clog2(DVD_W + 1);

    typedef struct packed {
        logic [DVD_W-1:0] dvd;
        logic [DVS_W-1:0] dvs;
        logic [DVS_W-1:0] rem;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             done;
    } quo_t;

    quo_t quo_d, quo_q;
    logic [DVS_W:0] trial;

    always_comb begin
        trial      = {quo_q.rem, quo_q.dvd[DVD_W-1]};
        quo_d      = quo_q;
        quo_d.done = 1'b0;
        if (start_i) begin
            quo_d.dvd = dvd_i;
            quo_d.dvs = dvs_i;
            quo_d.rem = '0;
            quo_d.cnt = CNT_W'(DVD_W);
            quo_d.run = 1'b1;
        end else if (quo_q.run) begin
            if (trial >= {1'b0, quo_q.dvs}) begin
                quo_d.rem = DVS_W'(trial - {1'b0, quo_q.dvs});
                quo_d.dvd = {quo_q.dvd[DVD_W-2:0], 1'b1};
            end else begin
                quo_d.rem = trial[DVS_W-1:0];
                quo_d.dvd = {quo_q.dvd[DVD_W-2:0], 1'b0};
            end
            quo_d.cnt = quo_q.cnt - CNT_W'(1);
            if (quo_q.cnt == CNT_W'(1)) begin
                quo_d.run  = 1'b0;
                quo_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) quo_q <= '0;
        else        quo_q <= quo_d;
    end

    assign done_o = quo_q.done;
    assign quo_o  = quo_q.dvd;

    // R6
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quo_q.run || quo_q.done) |-> (quo_q.rem < quo_q.dvs));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quo_q.done |-> (!quo_q.run && quo_q.cnt == '0));

endmodule

// File: rtl/sdclk_search.sv
module sdclk_search
    import sdclk_pkg::*;
#(
    parameter int                FREQ_W    = 32,
    parameter int                VER_W     = 8,
    parameter int                PRE_LOG   = 8,
    parameter int                DIV_MAX   = 16,
    parameter logic [VER_W-1:0]  EARLY_VER = 8'h13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [FREQ_W-1:0]             base_i,
    input  logic [FREQ_W-1:0]             req_i,
    input  logic [VER_W-1:0]              ver_i,
    input  logic                          quo_done_i,
    input  logic [FREQ_W-1:0]             quo_val_i,
    output logic                          quo_start_o,
    output logic [FREQ_W-1:0]             quo_dvd_o,
    output logic [$clog2(DIV_MAX+1)-1:0]  quo_dvs_o,
    output logic [PRE_LOG-1:0]            pre_f_o,
    output logic [$clog2(DIV_MAX)-1:0]    div_f_o,
    output logic                          en_o,
    output logic                          done_o,
    output logic [FREQ_W-1:0]             act_o
);

    localparam int K_W   = $clog2(PRE_LOG + 1);
    localparam int DIV_W = $clog2(DIV_MAX + 1);
    localparam int DF_W  = $clog2(DIV_MAX);
    localparam int PW    = FREQ_W + DIV_W + 1;

    typedef struct packed {
        srch_state_e       st;
        logic [FREQ_W-1:0] base;
        logic [FREQ_W-1:0] req;
        logic [K_W-1:0]    k;
        logic [DIV_W-1:0]  dv;
        logic              en;
        logic [PRE_LOG-1:0] pre_f;
        logic [DF_W-1:0]   div_f;
        logic [FREQ_W-1:0] act;
        logic              done;
    } srch_t;

    srch_t srch_d, srch_q;

    logic [FREQ_W-1:0]  scaled;
    logic [FREQ_W-1:0]  coarse;
    logic [PW-1:0]      need;
    logic [PRE_LOG:0]   pre_val;
    logic               pre_more;
    logic               div_more;

    always_comb begin
        scaled   = srch_q.base >> srch_q.k;
        coarse   = scaled >> 4;
        need     = PW'(srch_q.dv) * (PW'(srch_q.req) + PW'(1));
        pre_val  = (PRE_LOG+1)'(1) << srch_q.k;
        pre_more = (srch_q.k < K_W'(PRE_LOG)) && (coarse > srch_q.req);
        div_more = (srch_q.dv < DIV_W'(DIV_MAX)) && (PW'(scaled) >= need);

        srch_d      = srch_q;
        srch_d.done = 1'b0;
        case (srch_q.st)
            S_IDLE: begin
                if (start_i) begin
                    srch_d.base  = base_i;
                    srch_d.req   = req_i;
                    srch_d.en    = 1'b0;
                    srch_d.pre_f = '0;
                    srch_d.div_f = '0;
                    srch_d.k     = (ver_i < EARLY_VER) ? K_W'(1) : '0;
                    srch_d.dv    = DIV_W'(1);
                    if (req_i == '0) begin
                        srch_d.act  = '0;
                        srch_d.done = 1'b1;
                    end else begin
                        srch_d.st = S_PRE;
                    end
                end
            end
            S_PRE: begin
                if (pre_more) srch_d.k  = srch_q.k + K_W'(1);
                else          srch_d.st = S_DIV;
            end
            S_DIV: begin
                if (div_more) srch_d.dv = srch_q.dv + DIV_W'(1);
                else          srch_d.st = S_QUOT;
            end
            S_QUOT: begin
                if (quo_done_i) begin
                    srch_d.act   = quo_val_i;
                    srch_d.en    = 1'b1;
                    srch_d.pre_f = PRE_LOG'(pre_val >> 1);
                    srch_d.div_f = DF_W'(srch_q.dv - DIV_W'(1));
                    srch_d.st    = S_APPLY;
                end
            end
            S_APPLY: begin
                srch_d.done = 1'b1;
                srch_d.st   = S_IDLE;
            end
            default: srch_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) srch_q <= '0;
        else        srch_q <= srch_d;
    end

    assign quo_start_o = (srch_q.st == S_DIV) && !div_more;
    assign quo_dvd_o   = scaled;
    assign quo_dvs_o   = srch_q.dv;
    assign pre_f_o     = srch_q.pre_f;
    assign div_f_o     = srch_q.div_f;
    assign en_o        = srch_q.en;
    assign done_o      = srch_q.done;
    assign act_o       = srch_q.act;

    // R5
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_q.st == S_PRE || srch_q.st == S_DIV || srch_q.st == S_QUOT)
        |-> (!srch_q.en && srch_q.pre_f == '0 && srch_q.div_f == '0));

    // R2
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_q.k <= K_W'(PRE_LOG));

    // R3
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_q.st != S_IDLE) |-> (srch_q.dv >= DIV_W'(1) && srch_q.dv <= DIV_W'(DIV_MAX)));

    // R7
    done_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srch_q.en) |=> srch_q.done);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_q.done |=> !srch_q.done);

    // R1
    zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_q.st == S_IDLE && start_i && req_i == '0)
        |=> (srch_q.done && srch_q.act == '0 && !srch_q.en));

    // R8
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_q.st != S_IDLE) |=> ($stable(srch_q.req) && $stable(srch_q.base)));

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
    parameter int RATIO_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               sd_clk_o
);

    typedef struct packed {
        logic               on;
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] n;
        logic               clk;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [RATIO_W-1:0] n_new;
    logic               wrap;

    always_comb begin
        n_new = (ratio_i < RATIO_W'(2)) ? RATIO_W'(2) : ratio_i;
        wrap  = (gen_q.cnt == gen_q.n - RATIO_W'(1));
        gen_d = gen_q;
        if (!gen_q.on) begin
            if (run_i) begin
                gen_d.on  = 1'b1;
                gen_d.cnt = '0;
                gen_d.n   = n_new;
            end
        end else if (wrap) begin
            gen_d.cnt = '0;
            if (run_i) gen_d.n  = n_new;
            else       gen_d.on = 1'b0;
        end else begin
            gen_d.cnt = gen_q.cnt + RATIO_W'(1);
        end
        gen_d.clk = gen_d.on && (gen_d.cnt < (gen_d.n >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sd_clk_o = gen_q.clk;

    // R10
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_q.on && gen_q.cnt != gen_q.n - RATIO_W'(1)) |=> ($stable(gen_q.n) && gen_q.on));

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_q.on |-> !gen_q.clk);

    // R9
    min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q.on |-> (gen_q.n >= RATIO_W'(2) && gen_q.cnt < gen_q.n));

endmodule

// File: rtl/sdclk_divgen.sv
module sdclk_divgen
    import sdclk_pkg::*;
#(
    parameter int               FREQ_W    = 32,
    parameter int               VER_W     = 8,
    parameter int               PRE_LOG   = 8,
    parameter int               DIV_MAX   = 16,
    parameter logic [VER_W-1:0] EARLY_VER = 8'h13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [FREQ_W-1:0]          base_freq_i,
    input  logic [FREQ_W-1:0]          req_freq_i,
    input  logic [VER_W-1:0]           vendor_ver_i,
    output logic [PRE_LOG-1:0]         pre_field_o,
    output logic [$clog2(DIV_MAX)-1:0] div_field_o,
    output logic                       int_clk_en_o,
    output logic                       host_clk_en_o,
    output logic                       per_clk_en_o,
    output logic                       sd_clk_o,
    output logic                       done_o,
    output logic [FREQ_W-1:0]          act_freq_o
);

    localparam int DIV_W   = $clog2(DIV_MAX + 1);
    localparam int DF_W    = $clog2(DIV_MAX);
    localparam int RATIO_W = PRE_LOG + DIV_W;

    logic                quo_start;
    logic [FREQ_W-1:0]   quo_dvd;
    logic [DIV_W-1:0]    quo_dvs;
    logic                quo_done;
    logic [FREQ_W-1:0]   quo_val;
    logic [PRE_LOG-1:0]  pre_f;
    logic [DF_W-1:0]     div_f;
    logic                en;
    logic [PRE_LOG:0]    pre_dec;
    logic [DIV_W-1:0]    div_dec;
    logic [RATIO_W-1:0]  ratio;

    sdclk_search #(
        .FREQ_W(FREQ_W), .VER_W(VER_W), .PRE_LOG(PRE_LOG),
        .DIV_MAX(DIV_MAX), .EARLY_VER(EARLY_VER)
    ) u_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .base_i(base_freq_i), .req_i(req_freq_i), .ver_i(vendor_ver_i),
        .quo_done_i(quo_done), .quo_val_i(quo_val),
        .quo_start_o(quo_start), .quo_dvd_o(quo_dvd), .quo_dvs_o(quo_dvs),
        .pre_f_o(pre_f), .div_f_o(div_f), .en_o(en),
        .done_o(done_o), .act_o(act_freq_o)
    );

    sdclk_quot #(.DVD_W(FREQ_W), .DVS_W(DIV_W)) u_quot (
        .clk(clk), .rst_n(rst_n), .start_i(quo_start),
        .dvd_i(quo_dvd), .dvs_i(quo_dvs),
        .done_o(quo_done), .quo_o(quo_val)
    );

    always_comb begin
        pre_dec = (pre_f == '0) ? (PRE_LOG+1)'(1) : {pre_f, 1'b0};
        div_dec = DIV_W'(div_f) + DIV_W'(1);
        ratio   = RATIO_W'(pre_dec) * RATIO_W'(div_dec);
    end

    sdclk_gen #(.RATIO_W(RATIO_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .run_i(en),
        .ratio_i(ratio), .sd_clk_o(sd_clk_o)
    );

    assign pre_field_o   = pre_f;
    assign div_field_o   = div_f;
    assign int_clk_en_o  = en;
    assign host_clk_en_o = en;
    assign per_clk_en_o  = en;

endmodule

// File: tb/sdclk_divgen_tb.sv
module sdclk_divgen_tb;

    localparam int W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base = '0;
    logic [31:0] req = '0;
    logic [7:0]  ver = '0;
    logic [7:0]  pre_field_o;
    logic [3:0]  div_field_o;
    logic        int_clk_en_o, host_clk_en_o, per_clk_en_o, sd_clk_o, done_o;
    logic [31:0] act_freq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sdclk_divgen u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .base_freq_i(base), .req_freq_i(req), .vendor_ver_i(ver),
        .pre_field_o(pre_field_o), .div_field_o(div_field_o),
        .int_clk_en_o(int_clk_en_o), .host_clk_en_o(host_clk_en_o),
        .per_clk_en_o(per_clk_en_o), .sd_clk_o(sd_clk_o),
        .done_o(done_o), .act_freq_o(act_freq_o)
    );

    task automatic chk(input bit ok, input string what, input longint a, input longint e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, a, e);
        end
    endtask

    task automatic model(input longint b, input longint r, input int v,
                         output longint pre, output longint dv,
                         output longint act, output int lat);
        int steps;
        pre = 1; dv = 1; act = 0; lat = 1;
        if (r != 0) begin
            pre   = (v < 'h13) ? 2 : 1;
            steps = 1;
            while ((b / pre / 16 > r) && pre < 256) begin
                pre = pre * 2;
                steps++;
            end
            steps++;
            while ((b / pre / dv > r) && dv < 16) begin
                dv++;
                steps++;
            end
            act = b / pre / dv;
            lat = steps + W + 3;
        end
    endtask

    task automatic run_case(input longint b, input longint r, input int v);
        longint ep, ed, ea;
        int el, lat;
        bit en_m1, en_m2, all_en, all_off;
        model(b, r, v, ep, ed, ea, el);
        @(negedge clk);
        base = b[31:0]; req = r[31:0]; ver = v[7:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (r != 0) begin
            all_off = !int_clk_en_o && !host_clk_en_o && !per_clk_en_o;
            chk(all_off && pre_field_o == 0 && div_field_o == 0,
                "R5 gate cleared after start", {pre_field_o, div_field_o}, 0);
        end
        en_m1 = 1'b0; en_m2 = 1'b0;
        while (!done_o && lat < 5000) begin
            en_m2 = en_m1;
            en_m1 = per_clk_en_o;
            @(negedge clk);
            lat++;
        end
        chk(lat == el, "R7 done latency", lat, el);
        all_en = int_clk_en_o && host_clk_en_o && per_clk_en_o;
        if (r == 0) begin
            chk(!int_clk_en_o && !host_clk_en_o && !per_clk_en_o && act_freq_o == 0
                && pre_field_o == 0 && div_field_o == 0,
                "R1 zero request", act_freq_o, 0);
        end else begin
            chk(en_m1 && !en_m2, "R7 enables one cycle before done", {en_m2, en_m1}, 1);
            chk(all_en, "R5 all enables set", {int_clk_en_o, host_clk_en_o, per_clk_en_o}, 7);
            chk(pre_field_o == (ep >> 1), "R2 R4 prescaler field", pre_field_o, ep >> 1);
            chk(div_field_o == ed - 1, "R3 R4 divisor field", div_field_o, ed - 1);
            chk(act_freq_o == ea, "R6 achieved frequency", act_freq_o, ea);
        end
        @(negedge clk);
        chk(!done_o, "R7 done single cycle", done_o, 0);
    endtask

    task automatic measure_clk(input int exp_n);
        int g, hi, per;
        bit p;
        g = 0;
        do begin
            p = sd_clk_o;
            @(negedge clk);
            g++;
        end while (!(p == 1'b0 && sd_clk_o == 1'b1) && g < 20000);
        hi = 0; per = 0;
        do begin
            if (sd_clk_o) hi++;
            p = sd_clk_o;
            @(negedge clk);
            per++;
        end while (!(p == 1'b0 && sd_clk_o == 1'b1) && per < 20000);
        chk(per == exp_n, "R9 R10 divided clock period", per, exp_n);
        chk(hi == exp_n / 2, "R9 divided clock high time", hi, exp_n / 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        bit hold_low;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!per_clk_en_o && !done_o && !sd_clk_o && pre_field_o == 0 && div_field_o == 0
            && act_freq_o == 0, "reset state R5", act_freq_o, 0);

        // sweeps over the request for two vendor versions (R2 R3 R4 R6 R7)
        for (int r = 0; r <= 1000; r += 7) run_case(1000, r, 'h13);
        for (int r = 0; r <= 5000; r += 37) run_case(5000, r, 'h12);
        for (int v = 'h10; v <= 'h15; v++) run_case(20000, 300, v);

        // wide values and extremes (R6 lowest frequency)
        run_case(100000000, 400000, 'h13);
        run_case(100000000, 25000000, 'h12);
        run_case(100000000, 50000000, 'h13);
        run_case(100000000, 200000000, 'h13);
        run_case(100000000, 64'hFFFFFFFF, 'h12);
        run_case(64'hFFFFFFFF, 1, 'h12);
        run_case(0, 5, 'h13);
        run_case(1000000, 1, 'h13);
        chk(act_freq_o == 1000000 / 4096, "R6 lowest reachable frequency", act_freq_o, 1000000 / 4096);
        measure_clk(4096);

        // divided clock shapes (R9 R10)
        run_case(1000, 400, 'h13);
        measure_clk(3);
        run_case(1000, 300, 'h13);
        measure_clk(4);
        run_case(1000, 1000, 'h13);
        measure_clk(2);
        run_case(1000, 1000, 'h12);
        measure_clk(2);
        run_case(8000, 100, 'h13);
        measure_clk(80);

        // clock stays low once stopped (R9)
        run_case(1000, 0, 'h13);
        repeat (100) @(negedge clk);
        hold_low = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (sd_clk_o) hold_low = 1'b0;
            @(negedge clk);
        end
        chk(hold_low, "R9 clock low while stopped", !hold_low, 0);

        // start during a search is ignored (R8)
        @(negedge clk);
        base = 1000; req = 500; ver = 'h13; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        req = 100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done_o && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        chk(div_field_o == 1, "R8 second start ignored divisor", div_field_o, 1);
        chk(act_freq_o == 500, "R8 second start ignored frequency", act_freq_o, 500);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule